// File: doc/BRIEF.md
# Bit-Serial Two's-Complement Negator

This block forms the arithmetic negation of a binary integer that arrives one bit per clock, lowest-weight bit first. The negated bit comes out in the same cycle as the bit it comes from. The rule is simple. Every bit up to and including the first 1 of the word passes through unchanged. Every bit after that first 1 leaves inverted.

The only memory is a single flag. It records whether the current word has already carried a 1. Two things return the flag to its idle value: a synchronous reset, and a start-of-word strobe. The strobe is raised in the same cycle as the first bit of each word, so words can follow one another with no idle cycles between them. The block does not count word length. A word is the run of bits from one strobe up to the next. When the input is the most negative value, the output equals the input, and nothing signals this case.

Top module: `serial_negator`

## Requirements
- R1: When `rst` is high at a rising edge, the flag is cleared. In the following cycle, with `sow_i` low, `z_o` equals `x_i`.
- R2: While the flag is clear, an input bit of 0 gives an output of 0 and the flag stays clear.
- R3: While the flag is clear, an input bit of 1 gives an output of 1 and the flag is set at the next edge.
- R4: Once the flag is set, it stays set until reset or a start-of-word strobe, and `z_o` is the inverse of `x_i`.
- R5: When `sow_i` is high, the bit in that cycle is treated as the first bit of a new word. `z_o` equals `x_i` whatever the earlier flag was, and the flag's next value equals `x_i`.
- R6: An N-bit word w, fed lowest bit first with `sow_i` on bit 0, yields the output bits of (2^N - w) mod 2^N, lowest bit first. For example, 8'h1C yields 8'hE4 and 8'h2D yields 8'hD3.
- R7: A word of all zeros yields all zeros and leaves the flag clear. A following 0 bit with `sow_i` low gives 0.
- R8: The most negative word, 8'h80, yields 8'h80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the flag |
| sow_i | input | 1 | Start-of-word strobe; marks the current bit as bit 0 of a word |
| x_i | input | 1 | Serial input bit, lowest weight first |
| z_o | output | 1 | Serial negated bit, valid in the same cycle as `x_i` |

## Verification
The assertions assume that `x_i` and `sow_i` are settled at every rising edge. They also assume that `sow_i` marks exactly the first bit of each word, so the flag they check always belongs to the word in flight. The bench changes its inputs only on falling edges. It raises `sow_i` only together with bit 0 of each word, and it keeps `rst` high from time zero until after the first edges, so the flag is never unknown while the checks are armed.

// File: rtl/serial_negator_pkg.sv
package serial_negator_pkg;
  typedef enum logic {
    SEEN_NONE = 1'b0,
    SEEN_ONE  = 1'b1
  } seen_t;
endpackage

// File: rtl/seen_flag.sv
module seen_flag
  import serial_negator_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sow_i,
  input  logic  x_i,
  output seen_t flag_q
);
  seen_t flag_d;

  always_comb begin
    if (sow_i)
      flag_d = x_i ? SEEN_ONE : SEEN_NONE;
    else if (flag_q == SEEN_ONE)
      flag_d = SEEN_ONE;
    else
      flag_d = x_i ? SEEN_ONE : SEEN_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= SEEN_NONE;
    else     flag_q <= flag_d;
  end

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q == SEEN_ONE && !sow_i) |=> (flag_q == SEEN_ONE));
  a_r5_sow_loads_bit: assert property (@(posedge clk) disable iff (rst)
    sow_i |=> (flag_q == (x_i ? SEEN_ONE : SEEN_NONE)) || $past(x_i) == (flag_q == SEEN_ONE));
endmodule

// File: rtl/flip_stage.sv
module flip_stage
  import serial_negator_pkg::*;
(
  input  logic  sow_i,
  input  logic  x_i,
  input  seen_t flag_q,
  output logic  z_o
);
  logic invert;

  always_comb begin
    invert = (flag_q == SEEN_ONE) && !sow_i;
    z_o    = x_i ^ invert;
  end
endmodule

// File: rtl/serial_negator.sv
module serial_negator
  import serial_negator_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sow_i,
  input  logic x_i,
  output logic z_o
);
  seen_t flag_q;

  seen_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .sow_i  (sow_i),
    .x_i    (x_i),
    .flag_q (flag_q)
  );

  flip_stage u_flip (
    .sow_i  (sow_i),
    .x_i    (x_i),
    .flag_q (flag_q),
    .z_o    (z_o)
  );

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (flag_q == SEEN_NONE));
  a_r2_copy_when_clear: assert property (@(posedge clk) disable iff (rst)
    (flag_q == SEEN_NONE) |-> (z_o == x_i));
  a_r3_one_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (flag_q == SEEN_NONE && !sow_i && x_i) |=> (flag_q == SEEN_ONE));
  a_r4_invert_when_set: assert property (@(posedge clk) disable iff (rst)
    (flag_q == SEEN_ONE && !sow_i) |-> (z_o == !x_i));
  a_r5_sow_copies: assert property (@(posedge clk) disable iff (rst)
    sow_i |-> (z_o == x_i));
endmodule

// File: tb/serial_negator_bench.sv
`timescale 1ns/1ps
module serial_negator_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sow_i = 1'b0;
  logic x_i = 1'b0;
  logic z_o;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  serial_negator u_serial_negator (
    .clk(clk), .rst(rst), .sow_i(sow_i), .x_i(x_i), .z_o(z_o)
  );

  task automatic check_bit(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  // drive one bit at a falling edge, return z before the next rising edge
  task automatic drive_bit(input logic s, input logic x, output logic z);
    @(negedge clk);
    sow_i = s;
    x_i = x;
    #1;
    z = z_o;
  endtask

  task automatic run_word(input string req, input logic [7:0] w);
    logic [7:0] got;
    logic [7:0] exp;
    logic z;
    exp = 8'(9'd256 - {1'b0, w});
    for (int i = 0; i < 8; i++) begin
      drive_bit(i == 0, w[i], z);
      got[i] = z;
    end
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s word %h got %h expected %h", req, w, got, exp);
    end
  endtask

  task automatic t_reset;
    logic z;
    drive_bit(1'b1, 1'b1, z);
    drive_bit(1'b0, 1'b1, z);
    @(negedge clk); rst = 1'b1; sow_i = 1'b0; x_i = 1'b0;
    @(negedge clk); rst = 1'b0;
    drive_bit(1'b0, 1'b1, z);
    check_bit("R1 copy after reset", z, 1'b1);
  endtask

  task automatic t_clear_and_set;
    logic z;
    drive_bit(1'b1, 1'b0, z);
    check_bit("R2 zero while clear", z, 1'b0);
    drive_bit(1'b0, 1'b0, z);
    check_bit("R2 flag stays clear", z, 1'b0);
    drive_bit(1'b0, 1'b1, z);
    check_bit("R3 one copied", z, 1'b1);
    drive_bit(1'b0, 1'b1, z);
    check_bit("R3 flag set, one inverted", z, 1'b0);
    drive_bit(1'b0, 1'b0, z);
    check_bit("R4 zero inverted", z, 1'b1);
    drive_bit(1'b0, 1'b0, z);
    check_bit("R4 still set", z, 1'b1);
  endtask

  task automatic t_sow;
    logic z;
    drive_bit(1'b1, 1'b0, z);
    check_bit("R5 sow zero copied", z, 1'b0);
    drive_bit(1'b0, 1'b1, z);
    check_bit("R5 flag cleared by sow", z, 1'b1);
    drive_bit(1'b1, 1'b1, z);
    check_bit("R5 sow one copied over set flag", z, 1'b1);
    drive_bit(1'b0, 1'b1, z);
    check_bit("R5 sow one sets flag", z, 1'b0);
  endtask

  task automatic t_zero_word;
    logic z;
    run_word("R7 zero word", 8'h00);
    drive_bit(1'b0, 1'b0, z);
    check_bit("R7 flag clear after zero word", z, 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check_bit("R1 reset state copies", z_o, x_i);
    t_reset();
    t_clear_and_set();
    t_sow();
    run_word("R6 example one", 8'h1C);
    run_word("R6 example two", 8'h2D);
    t_zero_word();
    run_word("R8 most negative", 8'h80);
    run_word("R6 all ones", 8'hFF);
    run_word("R6 one", 8'h01);
    for (int k = 0; k < 60; k++) begin
      run_word("R6 random", 8'($urandom));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule